// File: doc/BRIEF.md
# I2C Interrupt Status and Vector Unit

This block sits beside an I2C controller core and turns the core's one-cycle event strobes into sticky flags that a CPU can inspect. The seven events are arbitration lost, missing acknowledge, access ready, receive data ready, transmit data ready, stop condition seen and addressed as slave. Each event has a flag and an enable bit. The CPU finds the most urgent enabled event by reading a vector register that returns a fixed small code per event. The status word also shows two live bus levels: bus busy and receive shift register full.

A CPU service routine reads the vector register in a loop until it returns zero. Each read hands back the highest-priority enabled event and retires it. The routine can also clear flags in bulk by writing ones to the status word. The single interrupt output stays high while any enabled flag is pending.

Top module: `i2c_irq_vec`

## Requirements
- R1: After a synchronous active-low reset, all flags and all enable bits are 0, the vector reads 0, `irq` is low and `reg_rdata` is 0.
- R2: A one-cycle event strobe sets its flag on the next clock edge. Status word bit k holds the flag whose vector code is k+1: bit 0 arbitration lost, bit 1 missing acknowledge, bit 2 access ready, bit 3 receive ready, bit 4 transmit ready, bit 5 stop seen, bit 6 addressed as slave.
- R3: A write to the status word (address 1) clears each flag whose data bit is 1. Flags whose data bit is 0 are left unchanged.
- R4: If an event strobe arrives in the same cycle as a clear of its flag, whether by write or by vector read, the flag ends up set.
- R5: Status bit 12 shows the bus-busy level and bit 11 shows the receive-shift-full level, both as sampled at the read. Writes have no effect on them. All status bits not named here read 0.
- R6: The enable register (address 0) is read/write on bits 6..0, with the same bit positions as the status flags. Its higher bits read 0.
- R7: The vector register (address 2) returns the lowest code among flags that are both pending and enabled. The codes are arbitration lost 1, missing acknowledge 2, access ready 3, receive ready 4, transmit ready 5, stop seen 6, addressed as slave 7. It returns 0 when nothing enabled is pending. Writes to address 2 are ignored.
- R8: Reading the vector register clears only the flag it reports. Masked flags and other pending flags remain.
- R9: `irq` is high exactly when at least one flag is both pending and enabled.
- R10: Read data is registered. `reg_rdata` shows the value selected by a read one clock edge after `reg_rd`, holds its value when no read is made, and returns 0 for address 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_arb_lost | input | 1 | Arbitration lost strobe |
| ev_nack | input | 1 | Missing acknowledge strobe |
| ev_acc_rdy | input | 1 | Access ready strobe |
| ev_rx_rdy | input | 1 | Receive data ready strobe |
| ev_tx_rdy | input | 1 | Transmit data ready strobe |
| ev_stop | input | 1 | Stop condition seen strobe |
| ev_slave | input | 1 | Addressed as slave strobe |
| lvl_busy | input | 1 | Bus busy level |
| lvl_rsf | input | 1 | Receive shift register full level |
| reg_addr | input | 2 | Register select: 0 enable, 1 status, 2 vector |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data |
| irq | output | 1 | Level interrupt request |

## Verification
The first directed pattern sets all seven flags with every enable on, then drains the vector. This shows whether priority follows the code order and whether each read retires exactly one flag. A second pattern masks half the events, which separates pending-and-enabled from merely pending, both in the vector and on `irq`. Further directed cycles raise an event in the same cycle as its clear, and write ones onto the live level bits. These distinguish event-wins ordering and level pass-through from a plain write-one-to-clear. A long random mix of strobes, writes and reads then exercises interleavings against a bench model of the flags and enables.

// File: rtl/i2c_irq_pkg.sv
// Package: shared sizes and register selects for the I2C interrupt unit.
// Assumes flag index k corresponds to vector code k+1.
package i2c_irq_pkg;
    localparam int NUM_EV  = 7;
    localparam int DATA_W  = 16;
    localparam int ADDR_W  = 2;
    localparam int CODE_W  = $clog2(NUM_EV + 1);
    localparam int BUSY_BIT = 12;
    localparam int RSF_BIT  = 11;

    typedef enum logic [ADDR_W-1:0] {
        SEL_ENABLE = 2'd0,
        SEL_STATUS = 2'd1,
        SEL_VECTOR = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/i2c_irq_flags.sv
// Sticky flag bank: one flag per event. A strobe sets the flag; a clear
// request drops it. A strobe always wins over a clear in the same cycle.
// Assumes strobes and clears are synchronous to clk.
module i2c_irq_flags #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] ev,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flags
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        // Set-dominant sticky flag for event i.
        always_ff @(posedge clk) begin
            if (!rst_n)       flags[i] <= 1'b0;
            else if (ev[i])   flags[i] <= 1'b1;
            else if (clr[i])  flags[i] <= 1'b0;
        end

        assert_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
            ev[i] |=> flags[i]);
        assert_ev_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (ev[i] && clr[i]) |=> flags[i]);
        assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[i] && !ev[i]) |=> !flags[i]);
    end
endmodule

// File: rtl/i2c_irq_prio.sv
// Priority encoder: returns index+1 of the lowest set bit of 'active',
// or 0 when none is set. Purely combinational.
module i2c_irq_prio #(
    parameter int N = 7,
    localparam int CW = $clog2(N + 1)
) (
    input  logic [N-1:0]  active,
    output logic [CW-1:0] code
);
    // Scan from highest to lowest so the lowest set index is left last.
    always_comb begin
        code = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (active[i]) code = CW'(i + 1);
        end
    end

    assert_code_pending_R7: assert final (code == '0 || active[code - 1'b1]);
    assert_zero_idle_R7: assert final ((active != '0) || (code == '0));
endmodule

// File: rtl/i2c_irq_regs.sv
// Register port: holds the enable register, turns status writes and vector
// reads into flag clear requests, and registers read data.
// Assumes a read and a write may share a cycle; reads see pre-edge values.
module i2c_irq_regs
    import i2c_irq_pkg::*;
#(
    parameter int N  = NUM_EV,
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W,
    localparam int CW = $clog2(N + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          wr,
    input  logic          rd,
    input  logic [DW-1:0] wdata,
    input  logic [N-1:0]  flags,
    input  logic [CW-1:0] code,
    input  logic          busy,
    input  logic          rsf,
    output logic [N-1:0]  enable,
    output logic [N-1:0]  clr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] rd_mux;
    logic [N-1:0]  vec_clr;

    // Enable register, written at the enable select.
    always_ff @(posedge clk) begin
        if (!rst_n) enable <= '0;
        else if (wr && addr == SEL_ENABLE) enable <= wdata[N-1:0];
    end

    // One-hot clear of the event the vector currently reports.
    always_comb begin
        vec_clr = '0;
        if (rd && addr == SEL_VECTOR && code != '0) vec_clr[code - 1'b1] = 1'b1;
    end

    // Combined clear requests: write-one-to-clear plus vector-read retire.
    always_comb begin
        clr = vec_clr;
        if (wr && addr == SEL_STATUS) clr = clr | wdata[N-1:0];
    end

    // Read selection from current register state.
    always_comb begin
        rd_mux = '0;
        case (addr)
            SEL_ENABLE: rd_mux[N-1:0] = enable;
            SEL_STATUS: begin
                rd_mux[N-1:0]    = flags;
                rd_mux[BUSY_BIT] = busy;
                rd_mux[RSF_BIT]  = rsf;
            end
            SEL_VECTOR: rd_mux[CW-1:0] = code;
            default:    rd_mux = '0;
        endcase
    end

    // Registered read data, held between reads.
    always_ff @(posedge clk) begin
        if (!rst_n)  rdata <= '0;
        else if (rd) rdata <= rd_mux;
    end

    assert_vec_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && addr == SEL_VECTOR) |=> (rdata == DW'($past(code))));
    assert_live_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && addr == SEL_STATUS) |=> (rdata[BUSY_BIT] == $past(busy)));
    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> $stable(rdata));
endmodule

// File: rtl/i2c_irq_vec.sv
// Top: I2C interrupt status and vector unit. Collects seven event strobes
// into sticky flags, exposes enable/status/vector registers and one level
// interrupt. Assumes strobes are single-cycle and synchronous to clk.
module i2c_irq_vec
    import i2c_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_arb_lost,
    input  logic              ev_nack,
    input  logic              ev_acc_rdy,
    input  logic              ev_rx_rdy,
    input  logic              ev_tx_rdy,
    input  logic              ev_stop,
    input  logic              ev_slave,
    input  logic              lvl_busy,
    input  logic              lvl_rsf,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);
    logic [NUM_EV-1:0] ev_vec, flags, enable, clr;
    logic [CODE_W-1:0] code;

    assign ev_vec = {ev_slave, ev_stop, ev_tx_rdy, ev_rx_rdy,
                     ev_acc_rdy, ev_nack, ev_arb_lost};

    i2c_irq_flags #(.N(NUM_EV)) u_flags (
        .clk(clk), .rst_n(rst_n), .ev(ev_vec), .clr(clr), .flags(flags));

    i2c_irq_prio #(.N(NUM_EV)) u_prio (
        .active(flags & enable), .code(code));

    i2c_irq_regs #(.N(NUM_EV), .DW(DATA_W), .AW(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wr(reg_wr), .rd(reg_rd),
        .wdata(reg_wdata), .flags(flags), .code(code), .busy(lvl_busy),
        .rsf(lvl_rsf), .enable(enable), .clr(clr), .rdata(reg_rdata));

    // Interrupt request follows a nonzero vector.
    assign irq = (code != '0);

    assert_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((flags & enable) != '0));
    assert_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (!irq && reg_rdata == '0));
endmodule

// File: tb/i2c_irq_vec_bench.sv
// Bench: directed corners plus seeded random traffic against a model.
module i2c_irq_vec_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [6:0] ev = '0;
    logic lvl_busy = 1'b0, lvl_rsf = 1'b0;
    logic [1:0] reg_addr = '0;
    logic reg_wr = 1'b0, reg_rd = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic irq;

    int checks = 0, errors = 0;
    logic [6:0] m_pend = '0, m_en = '0;
    logic [15:0] m_rd = '0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    i2c_irq_vec u_i2c_irq_vec (
        .clk(clk), .rst_n(rst_n),
        .ev_arb_lost(ev[0]), .ev_nack(ev[1]), .ev_acc_rdy(ev[2]),
        .ev_rx_rdy(ev[3]), .ev_tx_rdy(ev[4]), .ev_stop(ev[5]), .ev_slave(ev[6]),
        .lvl_busy(lvl_busy), .lvl_rsf(lvl_rsf), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq));

    function automatic logic [2:0] prio(input logic [6:0] act);
        for (int i = 0; i < 7; i++) if (act[i]) return 3'(i + 1);
        return 3'd0;
    endfunction

    function automatic logic [15:0] readval(input logic [1:0] a, input logic b,
                                            input logic r);
        logic [15:0] v = '0;
        case (a)
            2'd0: v[6:0] = m_en;
            2'd1: begin v[6:0] = m_pend; v[12] = b; v[11] = r; end
            2'd2: v[2:0] = prio(m_pend & m_en);
            default: v = '0;
        endcase
        return v;
    endfunction

    task automatic check(input logic [15:0] act, input logic [15:0] exp,
                         input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One clock of stimulus; model update; checks after the edge.
    task automatic step(input logic [6:0] e, input logic b, input logic r,
                        input logic [1:0] a, input logic w, input logic rd,
                        input logic [15:0] wd, input string tag);
        logic [6:0] clrv;
        logic [2:0] c;
        @(negedge clk);
        ev = e; lvl_busy = b; lvl_rsf = r; reg_addr = a;
        reg_wr = w; reg_rd = rd; reg_wdata = wd;
        c = prio(m_pend & m_en);
        if (rd) m_rd = readval(a, b, r);
        clrv = '0;
        if (w && a == 2'd1) clrv = wd[6:0];
        if (rd && a == 2'd2 && c != 0) clrv[c - 1] = 1'b1;
        m_pend = (m_pend & ~clrv) | e;
        if (w && a == 2'd0) m_en = wd[6:0];
        @(posedge clk); #1;
        check(reg_rdata, m_rd, tag);
        check({15'd0, irq}, {15'd0, prio(m_pend & m_en) != 0}, "R9 irq");
        ev = '0; reg_wr = 1'b0; reg_rd = 1'b0;
    endtask

    initial begin
        #(5.0 * 150000);
        checks++; errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        check(reg_rdata, 16'h0, "R1 rdata");
        check({15'd0, irq}, 16'h0, "R1 irq");
        @(negedge clk); rst_n = 1'b1;
        step('0, 0, 0, 2'd0, 0, 1, 0, "R1 enable zero");
        step('0, 0, 0, 2'd2, 0, 1, 0, "R1 vector zero");
        // R2, R7, R8: all events, all enabled, drain by priority
        step(7'h7F, 0, 0, 2'd0, 1, 0, 16'hFFFF, "R6 write");
        step('0, 0, 0, 2'd0, 0, 1, 0, "R6 readback");
        step('0, 0, 0, 2'd1, 0, 1, 0, "R2 status");
        for (int k = 0; k < 8; k++) step('0, 0, 0, 2'd2, 0, 1, 0, "R7 R8 drain");
        // Masked events stay pending; vector skips them (R8, R9)
        step(7'h55, 0, 0, 2'd0, 1, 0, 16'h002A, "R6 mask");
        step('0, 0, 0, 2'd2, 0, 1, 0, "R9 masked vector");
        step(7'h02, 0, 0, 2'd2, 0, 1, 0, "R7 masked skip");
        step('0, 0, 0, 2'd2, 0, 1, 0, "R8 retire");
        step('0, 0, 0, 2'd1, 0, 1, 0, "R8 masked remain");
        // R3: zero bits leave flags, one bits clear
        step('0, 0, 0, 2'd1, 1, 0, 16'h0004, "R3 w1c");
        step('0, 0, 0, 2'd1, 0, 1, 0, "R3 status");
        // R4: event together with clear
        step(7'h01, 0, 0, 2'd1, 1, 0, 16'h0001, "R4 write clear");
        step('0, 0, 0, 2'd1, 0, 1, 0, "R4 status");
        step(7'h7F, 0, 0, 2'd0, 1, 0, 16'h0001, "R6 only bit0");
        step(7'h01, 0, 0, 2'd2, 0, 1, 0, "R4 vector clear");
        step('0, 0, 0, 2'd1, 0, 1, 0, "R4 status after");
        // R5: live levels, writes ignored
        step('0, 1, 1, 2'd1, 1, 1, 16'hFFFF, "R5 live");
        step('0, 1, 0, 2'd1, 0, 1, 0, "R5 busy only");
        step('0, 0, 1, 2'd1, 0, 1, 0, "R5 rsf only");
        // R10: address 3, write to vector ignored, hold
        step(7'h08, 0, 0, 2'd2, 1, 0, 16'hFFFF, "R7 vector write");
        step('0, 0, 0, 2'd3, 1, 1, 16'hFFFF, "R10 addr3");
        step('0, 0, 0, 2'd1, 0, 0, 0, "R10 hold");
        // Random traffic
        for (int n = 0; n < 3000; n++) begin
            logic [6:0] e;
            e = ($urandom_range(0, 3) == 0) ? 7'($urandom) : 7'h0;
            step(e, 1'($urandom), 1'($urandom), 2'($urandom),
                 ($urandom_range(0, 4) == 0), ($urandom_range(0, 2) == 0),
                 16'($urandom), "R7 random");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule